// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Unit

This block gathers the single-cycle event pulses that an I2C bus engine produces and keeps them in two status words. The first status word holds the transfer events (start issued, address phase done, byte finished, transmit buffer empty, receive buffer full) and the three error conditions (no acknowledge, arbitration lost, bus error). The second status word holds a bus-busy indication. Each flag stays set until software runs the access sequence that clears it.

Three enable bits in a control word decide which flags reach the two interrupt lines. Error conditions go to their own line. The two buffer-level flags only interrupt when a second buffer enable is also set, which lets software poll the data path while it still takes protocol events by interrupt. All accesses go through one register port with a single access strobe and a write qualifier. Read data is returned combinationally in the cycle of the access.

Top module: `i2c_status_unit`

## Requirements
- R1: After reset, both status words, the control word, both interrupt lines and the clear-sequence state are all zero.
- R2: A pulse on an event input sets its flag on the next clock edge, and the flag holds until it is cleared. Status word 1 positions: start issued bit 0, address done bit 1, byte finished bit 2, receive full bit 6, transmit empty bit 7, bus error bit 8, arbitration lost bit 9, no acknowledge bit 10.
- R3: `irq_evt` is high when the event enable is set and any of bits 0..2 is set. It is also high when the event enable and the buffer enable are both set and bit 6 or bit 7 is set. It is low in every other case.
- R4: `irq_err` is high exactly when the error enable is set and any of bits 8..10 is set.
- R5: The address-done flag clears only when a read of status word 1 is followed by a read of status word 2 as the next register access. A read of status word 2 on its own, or one that follows another access in between, leaves the flag set.
- R6: The start-issued flag clears when a read of status word 1 is followed directly by a write to the data register. A data write that is not directly preceded by a read of status word 1 leaves it set.
- R7: The byte-finished flag clears when a read of status word 1 is followed directly by a data register read or write.
- R8: A data register write clears transmit empty. A data register read clears receive full.
- R9: Writing 0 to bit 8, 9 or 10 of status word 1 clears that error flag. Writing 1 leaves it unchanged, and writes never change any other status bit.
- R10: An event pulse that arrives in the same cycle as a clearing access wins, and the flag remains set.
- R11: Status word 2 bit 1 (busy) is set by a detected START and cleared by a detected STOP. If both arrive in the same cycle, busy ends up set.
- R12: Register select codes: 0 control, 1 status word 1, 2 status word 2, 3 data. Control enables are error enable bit 8, event enable bit 9 and buffer enable bit 10. Only those bits are writable, and all other control bits read as 0. A data register read returns 0. `reg_rdata` shows the selected word in the cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start_done | input | 1 | Start condition issued pulse |
| ev_addr_done | input | 1 | Address phase completed pulse |
| ev_byte_done | input | 1 | Byte transfer finished pulse |
| ev_tx_empty | input | 1 | Transmit buffer empty pulse |
| ev_rx_full | input | 1 | Receive buffer full pulse |
| ev_nack | input | 1 | Acknowledge failure pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_bus_err | input | 1 | Misplaced START/STOP pulse |
| bus_start_seen | input | 1 | START detected on the bus |
| bus_stop_seen | input | 1 | STOP detected on the bus |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write when high |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of selected register |
| irq_evt | output | 1 | Event interrupt |
| irq_err | output | 1 | Error interrupt |
| stat1 | output | 16 | Status word 1 |
| stat2 | output | 16 | Status word 2 |

## Verification
Every flag set or clear lands on the clock edge after the pulse or access. The interrupt lines follow the flags and enables without another register, so they change on that same edge. Read data is combinational and is valid within the access cycle. The bench drives each stimulus on a falling edge and captures read data 1 ns after driving it. It checks flags and interrupts on the next falling edge, which is half a period after the edge that updates them. The priority cases put the pulse and the clearing access in one driven cycle and check the outcome on the following falling edge.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int WORD_W = 16;

  // status word 1 positions
  localparam int B_SB   = 0;
  localparam int B_ADDR = 1;
  localparam int B_BTF  = 2;
  localparam int B_RXNE = 6;
  localparam int B_TXE  = 7;
  localparam int B_BERR = 8;
  localparam int B_ARLO = 9;
  localparam int B_AF   = 10;
  // status word 2
  localparam int B_BUSY = 1;
  // control enables
  localparam int B_ERREN = 8;
  localparam int B_EVTEN = 9;
  localparam int B_BUFEN = 10;
  localparam int EN_W    = B_BUFEN - B_ERREN + 1;

  localparam logic [WORD_W-1:0] EVT_MASK = WORD_W'((1 << B_SB) | (1 << B_ADDR) | (1 << B_BTF));
  localparam logic [WORD_W-1:0] BUF_MASK = WORD_W'((1 << B_RXNE) | (1 << B_TXE));
  localparam logic [WORD_W-1:0] ERR_MASK = WORD_W'((1 << B_BERR) | (1 << B_ARLO) | (1 << B_AF));
  localparam logic [WORD_W-1:0] ST1_MASK = EVT_MASK | BUF_MASK | ERR_MASK;
  localparam logic [WORD_W-1:0] ST2_MASK = WORD_W'(1 << B_BUSY);

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ST1  = 2'd1,
    SEL_ST2  = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/i2c_stat_access.sv
module i2c_stat_access
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] st1_clr,
  output logic              ctrl_wr
);
  logic arm_q, arm_d;
  logic st1_rd, st2_rd, dat_rd, dat_wr, st1_wr;

  always_comb begin
    st1_rd  = reg_en && !reg_we && (reg_addr == SEL_ST1);
    st2_rd  = reg_en && !reg_we && (reg_addr == SEL_ST2);
    dat_rd  = reg_en && !reg_we && (reg_addr == SEL_DATA);
    dat_wr  = reg_en &&  reg_we && (reg_addr == SEL_DATA);
    st1_wr  = reg_en &&  reg_we && (reg_addr == SEL_ST1);
    ctrl_wr = reg_en &&  reg_we && (reg_addr == SEL_CTRL);
    // any access consumes the armed state; only a status-1 read re-arms
    arm_d   = reg_en ? st1_rd : arm_q;
  end

  always_comb begin
    st1_clr = '0;
    st1_clr[B_SB]   = arm_q && dat_wr;
    st1_clr[B_BTF]  = arm_q && (dat_wr || dat_rd);
    st1_clr[B_ADDR] = arm_q && st2_rd;
    st1_clr[B_TXE]  = dat_wr;
    st1_clr[B_RXNE] = dat_rd;
    if (st1_wr) st1_clr = st1_clr | (~reg_wdata & ERR_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (reg_en) arm_q <= arm_d;
  end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags #(
  parameter int                W    = 16,
  parameter logic [W-1:0]      IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  logic [W-1:0] flg_q, flg_d;
  logic         upd;

  // set beats clear in the same cycle
  always_comb begin
    flg_d = (set_vec | (flg_q & ~clr_vec)) & IMPL;
    upd   = |(set_vec | clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flg_q <= '0;
    else if (upd) flg_q <= flg_d;
  end

  assign flags = flg_q;
endmodule

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl #(
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [EW-1:0] wdata,
  output logic [EW-1:0] en
);
  logic [EW-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= wdata;
  end

  assign en = en_q;
endmodule

// File: rtl/i2c_stat_irq_gate.sv
module i2c_stat_irq_gate
  import i2c_stat_pkg::*;
(
  input  logic [WORD_W-1:0] st1,
  input  logic              err_en,
  input  logic              evt_en,
  input  logic              buf_en,
  output logic              irq_evt,
  output logic              irq_err
);
  logic any_evt, any_buf, any_err;

  always_comb begin
    any_evt = |(st1 & EVT_MASK);
    any_buf = |(st1 & BUF_MASK);
    any_err = |(st1 & ERR_MASK);
    irq_evt = evt_en && (any_evt || (buf_en && any_buf));
    irq_err = err_en && any_err;
  end
endmodule

// File: rtl/i2c_status_unit.sv
module i2c_status_unit
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start_done,
  input  logic              ev_addr_done,
  input  logic              ev_byte_done,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_full,
  input  logic              ev_nack,
  input  logic              ev_arb_lost,
  input  logic              ev_bus_err,
  input  logic              bus_start_seen,
  input  logic              bus_stop_seen,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq_evt,
  output logic              irq_err,
  output logic [WORD_W-1:0] stat1,
  output logic [WORD_W-1:0] stat2
);
  logic [WORD_W-1:0] st1_set, st1_clr, st2_set, st2_clr, ctrl_word;
  logic [EN_W-1:0]   en;
  logic              ctrl_wr;

  always_comb begin
    st1_set         = '0;
    st1_set[B_SB]   = ev_start_done;
    st1_set[B_ADDR] = ev_addr_done;
    st1_set[B_BTF]  = ev_byte_done;
    st1_set[B_RXNE] = ev_rx_full;
    st1_set[B_TXE]  = ev_tx_empty;
    st1_set[B_BERR] = ev_bus_err;
    st1_set[B_ARLO] = ev_arb_lost;
    st1_set[B_AF]   = ev_nack;
    st2_set         = '0;
    st2_set[B_BUSY] = bus_start_seen;
    st2_clr         = '0;
    st2_clr[B_BUSY] = bus_stop_seen;
  end

  i2c_stat_access u_acc (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .st1_clr(st1_clr), .ctrl_wr(ctrl_wr)
  );

  i2c_stat_flags #(.W(WORD_W), .IMPL(ST1_MASK)) u_st1 (
    .clk(clk), .rst_n(rst_n), .set_vec(st1_set), .clr_vec(st1_clr), .flags(stat1)
  );

  i2c_stat_flags #(.W(WORD_W), .IMPL(ST2_MASK)) u_st2 (
    .clk(clk), .rst_n(rst_n), .set_vec(st2_set), .clr_vec(st2_clr), .flags(stat2)
  );

  i2c_stat_ctrl #(.EW(EN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr),
    .wdata(reg_wdata[B_BUFEN:B_ERREN]), .en(en)
  );

  i2c_stat_irq_gate u_irq (
    .st1(stat1),
    .err_en(en[B_ERREN-B_ERREN]),
    .evt_en(en[B_EVTEN-B_ERREN]),
    .buf_en(en[B_BUFEN-B_ERREN]),
    .irq_evt(irq_evt), .irq_err(irq_err)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[B_BUFEN:B_ERREN] = en;
    unique case (reg_addr)
      SEL_CTRL: reg_rdata = ctrl_word;
      SEL_ST1:  reg_rdata = stat1;
      SEL_ST2:  reg_rdata = stat2;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_status_unit_chk.sv
module i2c_status_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start_done,
  input logic       ev_nack,
  input logic       bus_start_seen,
  input logic       reg_en,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       wdata_af,
  input logic       sb_f,
  input logic       addr_f,
  input logic       btf_f,
  input logic       rxne_f,
  input logic       txe_f,
  input logic       berr_f,
  input logic       arlo_f,
  input logic       af_f,
  input logic       busy_f,
  input logic       irq_evt,
  input logic       irq_err
);
  // R2
  sb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_done |=> sb_f);
  // R10
  nack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |=> af_f);
  // R5
  addr_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_f) |-> $past(reg_en && !reg_we && reg_addr == 2'd2));
  // R9
  af_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(af_f) |-> $past(reg_en && reg_we && reg_addr == 2'd1 && !wdata_af));
  // R8
  txe_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txe_f) |-> $past(reg_en && reg_we && reg_addr == 2'd3));
  // R3
  evt_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |-> (sb_f || addr_f || btf_f || rxne_f || txe_f));
  // R4
  err_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (berr_f || arlo_f || af_f));
  // R11
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_seen |=> busy_f);
endmodule

bind i2c_status_unit i2c_status_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start_done(ev_start_done), .ev_nack(ev_nack),
  .bus_start_seen(bus_start_seen), .reg_en(reg_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .wdata_af(reg_wdata[10]),
  .sb_f(stat1[0]), .addr_f(stat1[1]), .btf_f(stat1[2]), .rxne_f(stat1[6]),
  .txe_f(stat1[7]), .berr_f(stat1[8]), .arlo_f(stat1[9]), .af_f(stat1[10]),
  .busy_f(stat2[1]), .irq_evt(irq_evt), .irq_err(irq_err)
);

// File: tb/tb_i2c_status_unit.sv
module tb_i2c_status_unit;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_start_done, ev_addr_done, ev_byte_done, ev_tx_empty, ev_rx_full;
  logic ev_nack, ev_arb_lost, ev_bus_err, bus_start_seen, bus_stop_seen;
  logic reg_en, reg_we;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, stat1, stat2;
  logic irq_evt, irq_err;
  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rd_cap;

  always #4 clk = ~clk;

  i2c_status_unit dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // event mask: status-1 bit positions; bit 12 = bus START, bit 13 = bus STOP
  task automatic drive_ev(input logic [15:0] m);
    ev_start_done = m[0]; ev_addr_done = m[1]; ev_byte_done = m[2];
    ev_rx_full = m[6]; ev_tx_empty = m[7]; ev_bus_err = m[8];
    ev_arb_lost = m[9]; ev_nack = m[10];
    bus_start_seen = m[12]; bus_stop_seen = m[13];
  endtask

  task automatic cyc(input logic en, input logic we, input logic [1:0] a,
                     input logic [15:0] wd, input logic [15:0] ev);
    @(negedge clk);
    reg_en = en; reg_we = we; reg_addr = a; reg_wdata = wd; drive_ev(ev);
    #1 rd_cap = reg_rdata;
    @(negedge clk);
    reg_en = 0; reg_we = 0; reg_wdata = '0; drive_ev('0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d); cyc(1, 1, a, d, '0); endtask
  task automatic rd(input logic [1:0] a); cyc(1, 0, a, '0, '0); endtask
  task automatic pulse(input logic [15:0] ev); cyc(0, 0, 2'd0, '0, ev); endtask

  task automatic t_reset;
    check("R1 stat1", stat1, 16'h0000);
    check("R1 stat2", stat2, 16'h0000);
    check("R1 irqs", {14'b0, irq_evt, irq_err}, 16'h0000);
    rd(2'd0); check("R1 ctrl", rd_cap, 16'h0000);
  endtask

  task automatic t_buffer_gate;
    wr(2'd0, 16'h0200);
    pulse(16'h0080);
    check("R2 txe set", stat1, 16'h0080);
    check("R3 no buf en", {15'b0, irq_evt}, 16'h0000);
    wr(2'd0, 16'h0600);
    check("R3 buf en", {15'b0, irq_evt}, 16'h0001);
    wr(2'd3, 16'h00AA);
    check("R8 txe clr", stat1, 16'h0000);
    check("R3 irq drop", {15'b0, irq_evt}, 16'h0000);
    pulse(16'h0040);
    check("R2 rxne set", stat1, 16'h0040);
    rd(2'd3); check("R12 data rd", rd_cap, 16'h0000);
    check("R8 rxne clr", stat1, 16'h0000);
  endtask

  task automatic t_start_flag;
    pulse(16'h0001);
    check("R3 sb irq", {15'b0, irq_evt}, 16'h0001);
    wr(2'd3, 16'h0011);
    check("R6 no arm", stat1, 16'h0001);
    rd(2'd1); check("R12 st1 rd", rd_cap, 16'h0001);
    wr(2'd3, 16'h0012);
    check("R6 sb clr", stat1, 16'h0000);
  endtask

  task automatic t_addr_flag;
    pulse(16'h0002);
    rd(2'd2);
    check("R5 st2 alone", stat1, 16'h0002);
    rd(2'd1); wr(2'd0, 16'h0600); rd(2'd2);
    check("R5 interleaved", stat1, 16'h0002);
    rd(2'd1); rd(2'd2);
    check("R5 addr clr", stat1, 16'h0000);
  endtask

  task automatic t_byte_flag;
    pulse(16'h0004);
    rd(2'd3);
    check("R7 no arm", stat1, 16'h0004);
    rd(2'd1); rd(2'd3);
    check("R7 btf clr", stat1, 16'h0000);
  endtask

  task automatic t_errors;
    wr(2'd0, 16'h0100);
    pulse(16'h0700);
    check("R2 err set", stat1, 16'h0700);
    check("R4 err irq", {14'b0, irq_evt, irq_err}, 16'h0001);
    wr(2'd1, 16'hFBFF);
    check("R9 af only", stat1, 16'h0300);
    check("R4 still", {15'b0, irq_err}, 16'h0001);
    wr(2'd1, 16'h0000);
    check("R9 all clr", stat1, 16'h0000);
    check("R4 drop", {15'b0, irq_err}, 16'h0000);
  endtask

  task automatic t_priority;
    pulse(16'h0400);
    cyc(1, 1, 2'd1, 16'h0000, 16'h0400);
    check("R10 af kept", stat1, 16'h0400);
    wr(2'd1, 16'h0000);
    pulse(16'h0002);
    rd(2'd1);
    cyc(1, 0, 2'd2, '0, 16'h0002);
    check("R10 addr kept", stat1, 16'h0002);
    rd(2'd1); rd(2'd2);
    check("R10 then clr", stat1, 16'h0000);
  endtask

  task automatic t_busy;
    pulse(16'h1000);
    check("R11 busy set", stat2, 16'h0002);
    rd(2'd2); check("R11 busy rd", rd_cap, 16'h0002);
    pulse(16'h2000);
    check("R11 busy clr", stat2, 16'h0000);
    pulse(16'h3000);
    check("R11 both", stat2, 16'h0002);
    pulse(16'h2000);
  endtask

  task automatic t_ctrl;
    wr(2'd0, 16'hFFFF);
    rd(2'd0); check("R12 ctrl mask", rd_cap, 16'h0700);
    wr(2'd0, 16'h0000);
    rd(2'd0); check("R12 ctrl zero", rd_cap, 16'h0000);
  endtask

  logic done = 1'b0;

  initial begin
    rst_n = 0; reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0; drive_ev('0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_buffer_gate;
    t_start_flag;
    t_addr_flag;
    t_byte_flag;
    t_errors;
    t_priority;
    t_busy;
    t_ctrl;
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule